// File: doc/BRIEF.md
# I2C Per-Byte Interrupt and Clock-Stretch Controller

This block decides when an I2C controller raises its per-byte interrupt flag and holds SCL low so that software can service the transfer. The bus engine feeds it single-cycle event strobes:
- byte complete, after the 8th data bit;
- acknowledge complete, after the 9th bit;
- arbitration lost;
- NACK received;
- receive data available.

The engine also supplies two level qualifiers: one marks the first byte of a transfer, the other marks a reserved-address match on that byte. Software writes reach the block as strobes with a value: writes to the interrupt flag, to the master-select bit, and to the repeated-start command bit.

A wait-select input chooses where the interrupt and the clock stretch happen. With wait-select at 0 they happen before the acknowledge bit. With wait-select at 1 they happen after it.

The flag has several ways to clear:
- software writes a 0 to it;
- software drops master-select (a stop request) while the bus is active;
- software issues a repeated-start command while the bus is active.

A DMA-mode input decides whether software may also set the flag by writing a 1. Dropping the enable input forces everything idle.

The controller is a three-state machine:
- **OFF**: the interface is disabled.
- **IDLE**: enabled, flag low.
- **HOLD**: flag high and SCL held.

The transitions are:
- **T_ENABLE**: OFF to IDLE when enable is high.
- **T_SET**: IDLE to HOLD on any set condition.
- **T_CLEAR**: HOLD to IDLE on any clear condition.
- **T_DISABLE**: any state to OFF when enable is low.

In HOLD, set conditions are ignored. Each transition takes effect on the clock edge after its inputs are seen. The master-select bit is kept in a small register inside the block. It is written by software and cleared when the block is disabled.

Top module: `i2c_byte_irq_ctrl`

## Requirements
- R1: With wait_sel=0, a byte_done pulse raises int_flag on the next cycle; an ack_done pulse alone does not.
- R2: With wait_sel=1, an ack_done pulse raises int_flag on the next cycle; a byte_done pulse alone does not.
- R3: An arb_lost pulse while first_byte=1 raises int_flag on the next cycle, whatever wait_sel is.
- R4: An arb_lost pulse while first_byte=0 raises int_flag only when wait_sel=0.
- R5: A nack pulse raises int_flag, except when is_master=1 and the internal master-select bit is 0 (a stop has been requested).
- R6: An rx_avail pulse raises int_flag, except when first_byte=1 and rsvd_addr=1 together.
- R7: A software flag write of 0 clears int_flag on the next cycle. A write of 1 raises it only when dma_mode=1 and has no effect when dma_mode=0.
- R8: While int_flag=1 and bus_active=1, a master-select write of 0 clears int_flag on the next cycle. With bus_active=0, the flag stays set.
- R9: While int_flag=1 and bus_active=1, a repeated-start command write clears int_flag on the next cycle.
- R10: scl_hold always equals int_flag, and irq equals int_flag AND irq_en.
- R11: While enable=0, int_flag and scl_hold are 0 and event strobes have no effect. Disabling also clears master-select to 0.
- R12: After reset, int_flag, scl_hold and irq are 0 and master-select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Interface enable |
| wait_sel | input | 1 | 0: interrupt and hold before ack; 1: after ack |
| dma_mode | input | 1 | DMA mode; allows software to set the flag |
| irq_en | input | 1 | Interrupt request enable |
| is_master | input | 1 | Controller is operating as master |
| bus_active | input | 1 | Bus is active for this controller |
| first_byte | input | 1 | Current byte is the first of the transfer |
| rsvd_addr | input | 1 | First byte matched a reserved address |
| byte_done | input | 1 | Strobe: 8th data bit finished |
| ack_done | input | 1 | Strobe: acknowledge bit finished |
| arb_lost | input | 1 | Strobe: arbitration lost |
| nack | input | 1 | Strobe: NACK received |
| rx_avail | input | 1 | Strobe: receive data available |
| sw_int_wr | input | 1 | Strobe: software write to the flag |
| sw_int_val | input | 1 | Value written to the flag |
| sw_mss_wr | input | 1 | Strobe: software write to master-select |
| sw_mss_val | input | 1 | Value written to master-select |
| sw_rsc_wr | input | 1 | Strobe: software repeated-start command |
| int_flag | output | 1 | Per-byte interrupt flag |
| scl_hold | output | 1 | Request to hold SCL low |
| irq | output | 1 | Interrupt request |

## Verification
A wrong internal state shows at int_flag and scl_hold on the cycle after the strobe that exposes it.

A machine stuck in HOLD keeps the clock stretched after a clearing write. A machine that misses a set condition leaves both outputs low where a rise was expected. A master-select register with the wrong value shows only indirectly: a NACK then either sets or fails to set the flag, or a master-select clear fails to release the flag. The bench therefore sets the register up before each NACK case.

// File: rtl/i2c_bic_pkg.sv
package i2c_bic_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_HOLD = 2'd2
    } bic_state_t;

    typedef struct packed {
        logic byte_done;
        logic ack_done;
        logic arb_lost;
        logic nack;
        logic rx_avail;
    } bic_events_t;
endpackage

// File: rtl/i2c_bic_mss.sv
module i2c_bic_mss (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic wr,
    input  logic val,
    output logic mss
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mss <= 1'b0;
        else if (!enable)
            mss <= 1'b0;
        else if (wr)
            mss <= val;
    end
endmodule

// File: rtl/i2c_bic_decode.sv
module i2c_bic_decode
    import i2c_bic_pkg::*;
(
    input  bic_events_t ev,
    input  logic        wait_sel,
    input  logic        dma_mode,
    input  logic        is_master,
    input  logic        mss,
    input  logic        bus_active,
    input  logic        first_byte,
    input  logic        rsvd_addr,
    input  logic        sw_int_wr,
    input  logic        sw_int_val,
    input  logic        sw_mss_wr,
    input  logic        sw_mss_val,
    input  logic        sw_rsc_wr,
    output logic        set_req,
    output logic        clr_req
);
    logic stop_pending;
    logic byte_point;
    logic arb_set;
    logic nack_set;
    logic rx_set;
    logic sw_set;

    always_comb begin
        stop_pending = is_master && !mss;
        // wait point: before the ack (wait_sel=0) or after it (wait_sel=1)
        byte_point   = wait_sel ? ev.ack_done : ev.byte_done;
        arb_set      = ev.arb_lost && (first_byte || !wait_sel);
        nack_set     = ev.nack && !stop_pending;
        rx_set       = ev.rx_avail && !(first_byte && rsvd_addr);
        sw_set       = sw_int_wr && sw_int_val && dma_mode;
        set_req      = byte_point || arb_set || nack_set || rx_set || sw_set;
        clr_req      = (sw_int_wr && !sw_int_val)
                    || (bus_active && sw_mss_wr && !sw_mss_val)
                    || (bus_active && sw_rsc_wr);
    end
endmodule

// File: rtl/i2c_byte_irq_ctrl.sv
module i2c_byte_irq_ctrl
    import i2c_bic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic wait_sel,
    input  logic dma_mode,
    input  logic irq_en,
    input  logic is_master,
    input  logic bus_active,
    input  logic first_byte,
    input  logic rsvd_addr,
    input  logic byte_done,
    input  logic ack_done,
    input  logic arb_lost,
    input  logic nack,
    input  logic rx_avail,
    input  logic sw_int_wr,
    input  logic sw_int_val,
    input  logic sw_mss_wr,
    input  logic sw_mss_val,
    input  logic sw_rsc_wr,
    output logic int_flag,
    output logic scl_hold,
    output logic irq
);
    bic_state_t  state_q, state_d;
    bic_events_t ev;
    logic        mss;
    logic        set_req;
    logic        clr_req;

    assign ev = '{byte_done: byte_done, ack_done: ack_done, arb_lost: arb_lost,
                  nack: nack, rx_avail: rx_avail};

    i2c_bic_mss u_mss (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .wr     (sw_mss_wr),
        .val    (sw_mss_val),
        .mss    (mss)
    );

    i2c_bic_decode u_decode (
        .ev         (ev),
        .wait_sel   (wait_sel),
        .dma_mode   (dma_mode),
        .is_master  (is_master),
        .mss        (mss),
        .bus_active (bus_active),
        .first_byte (first_byte),
        .rsvd_addr  (rsvd_addr),
        .sw_int_wr  (sw_int_wr),
        .sw_int_val (sw_int_val),
        .sw_mss_wr  (sw_mss_wr),
        .sw_mss_val (sw_mss_val),
        .sw_rsc_wr  (sw_rsc_wr),
        .set_req    (set_req),
        .clr_req    (clr_req)
    );

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_IDLE;
                ST_IDLE: if (set_req) state_d = ST_HOLD;
                ST_HOLD: if (clr_req) state_d = ST_IDLE;
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_HOLD: begin
                int_flag = 1'b1;
                scl_hold = 1'b1;
            end
            default: begin
                int_flag = 1'b0;
                scl_hold = 1'b0;
            end
        endcase
        irq = int_flag && irq_en;
    end
endmodule

// File: rtl/i2c_byte_irq_ctrl_chk.sv
module i2c_byte_irq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic wait_sel,
    input logic bus_active,
    input logic first_byte,
    input logic byte_done,
    input logic ack_done,
    input logic arb_lost,
    input logic sw_int_wr,
    input logic sw_int_val,
    input logic sw_mss_wr,
    input logic sw_mss_val,
    input logic sw_rsc_wr,
    input logic int_flag,
    input logic scl_hold
);
    logic no_clear;
    assign no_clear = !sw_int_wr && !sw_mss_wr && !sw_rsc_wr;

    p_before_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !wait_sel && byte_done && no_clear) |=> (int_flag || !enable));

    p_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && wait_sel && ack_done && no_clear) |=> (int_flag || !enable));

    p_arb_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && arb_lost && first_byte && no_clear) |=> (int_flag || !enable));

    p_sw_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_flag && sw_int_wr && !sw_int_val) |=> !int_flag);

    p_stop_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int_flag && bus_active && sw_mss_wr && !sw_mss_val) |=> !int_flag);

    p_rsc_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_flag && bus_active && sw_rsc_wr) |=> !int_flag);

    p_hold_tracks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold == int_flag);

    p_disable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !int_flag);
endmodule

bind i2c_byte_irq_ctrl i2c_byte_irq_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .wait_sel   (wait_sel),
    .bus_active (bus_active),
    .first_byte (first_byte),
    .byte_done  (byte_done),
    .ack_done   (ack_done),
    .arb_lost   (arb_lost),
    .sw_int_wr  (sw_int_wr),
    .sw_int_val (sw_int_val),
    .sw_mss_wr  (sw_mss_wr),
    .sw_mss_val (sw_mss_val),
    .sw_rsc_wr  (sw_rsc_wr),
    .int_flag   (int_flag),
    .scl_hold   (scl_hold)
);

// File: tb/test_i2c_byte_irq_ctrl.sv
module test_i2c_byte_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, wait_sel = 1'b0, dma_mode = 1'b0, irq_en = 1'b0;
    logic is_master = 1'b0, bus_active = 1'b0, first_byte = 1'b0, rsvd_addr = 1'b0;
    logic byte_done = 1'b0, ack_done = 1'b0, arb_lost = 1'b0, nack = 1'b0, rx_avail = 1'b0;
    logic sw_int_wr = 1'b0, sw_int_val = 1'b0, sw_mss_wr = 1'b0, sw_mss_val = 1'b0;
    logic sw_rsc_wr = 1'b0;
    logic int_flag, scl_hold, irq;
    int   n_run = 0, n_fail = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_byte_irq_ctrl i_i2c_byte_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wait_sel(wait_sel),
        .dma_mode(dma_mode), .irq_en(irq_en), .is_master(is_master),
        .bus_active(bus_active), .first_byte(first_byte), .rsvd_addr(rsvd_addr),
        .byte_done(byte_done), .ack_done(ack_done), .arb_lost(arb_lost),
        .nack(nack), .rx_avail(rx_avail), .sw_int_wr(sw_int_wr),
        .sw_int_val(sw_int_val), .sw_mss_wr(sw_mss_wr), .sw_mss_val(sw_mss_val),
        .sw_rsc_wr(sw_rsc_wr), .int_flag(int_flag), .scl_hold(scl_hold), .irq(irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // strobes are driven at a falling edge and dropped at the next one
    task automatic step();
        @(negedge clk);
        byte_done = 0; ack_done = 0; arb_lost = 0; nack = 0; rx_avail = 0;
        sw_int_wr = 0; sw_mss_wr = 0; sw_rsc_wr = 0;
    endtask

    task automatic sw_clear();
        sw_int_wr = 1; sw_int_val = 0; step();
    endtask

    task automatic t_reset_r12();
        chk("R12 flag after reset", int_flag, 1'b0);
        chk("R12 hold after reset", scl_hold, 1'b0);
        chk("R12 irq after reset", irq, 1'b0);
        // master-select 0 after reset: NACK as master is suppressed
        is_master = 1; nack = 1; step();
        chk("R12 mss reset suppresses nack", int_flag, 1'b0);
        is_master = 0;
    endtask

    task automatic t_before_ack_r1();
        wait_sel = 0;
        ack_done = 1; step();
        chk("R1 ack_done ignored", int_flag, 1'b0);
        byte_done = 1; step();
        chk("R1 byte_done sets flag", int_flag, 1'b1);
        chk("R1 hold follows", scl_hold, 1'b1);
        sw_clear();
    endtask

    task automatic t_after_ack_r2();
        wait_sel = 1;
        byte_done = 1; step();
        chk("R2 byte_done ignored", int_flag, 1'b0);
        ack_done = 1; step();
        chk("R2 ack_done sets flag", int_flag, 1'b1);
        sw_clear();
        wait_sel = 0;
    endtask

    task automatic t_arb_r3_r4();
        wait_sel = 1; first_byte = 1;
        arb_lost = 1; step();
        chk("R3 arb first byte wsel1", int_flag, 1'b1);
        sw_clear();
        first_byte = 0;
        arb_lost = 1; step();
        chk("R4 arb later byte wsel1 ignored", int_flag, 1'b0);
        wait_sel = 0;
        arb_lost = 1; step();
        chk("R4 arb later byte wsel0", int_flag, 1'b1);
        sw_clear();
    endtask

    task automatic t_nack_r5();
        is_master = 0;
        nack = 1; step();
        chk("R5 nack as slave", int_flag, 1'b1);
        sw_clear();
        is_master = 1; sw_mss_wr = 1; sw_mss_val = 1; step();
        nack = 1; step();
        chk("R5 nack master running", int_flag, 1'b1);
        sw_clear();
        sw_mss_wr = 1; sw_mss_val = 0; step();
        nack = 1; step();
        chk("R5 nack during stop request", int_flag, 1'b0);
        is_master = 0;
    endtask

    task automatic t_rx_r6();
        first_byte = 1; rsvd_addr = 1;
        rx_avail = 1; step();
        chk("R6 rx on reserved first byte ignored", int_flag, 1'b0);
        rsvd_addr = 0;
        rx_avail = 1; step();
        chk("R6 rx on plain first byte", int_flag, 1'b1);
        sw_clear();
        first_byte = 0;
    endtask

    task automatic t_sw_r7();
        dma_mode = 0;
        sw_int_wr = 1; sw_int_val = 1; step();
        chk("R7 write 1 without dma", int_flag, 1'b0);
        dma_mode = 1;
        sw_int_wr = 1; sw_int_val = 1; step();
        chk("R7 write 1 with dma", int_flag, 1'b1);
        sw_clear();
        chk("R7 write 0 clears", int_flag, 1'b0);
        dma_mode = 0;
    endtask

    task automatic t_stop_r8();
        byte_done = 1; step();
        bus_active = 0; sw_mss_wr = 1; sw_mss_val = 0; step();
        chk("R8 mss clear bus idle keeps flag", int_flag, 1'b1);
        bus_active = 1; sw_mss_wr = 1; sw_mss_val = 0; step();
        chk("R8 mss clear bus active clears", int_flag, 1'b0);
        bus_active = 0;
    endtask

    task automatic t_rsc_r9();
        byte_done = 1; step();
        bus_active = 1; sw_rsc_wr = 1; step();
        chk("R9 restart command clears", int_flag, 1'b0);
        chk("R9 hold released", scl_hold, 1'b0);
        bus_active = 0;
    endtask

    task automatic t_irq_r10();
        irq_en = 0; byte_done = 1; step();
        chk("R10 irq masked", irq, 1'b0);
        chk("R10 hold equals flag", scl_hold, 1'b1);
        irq_en = 1; #1;
        chk("R10 irq enabled", irq, 1'b1);
        sw_clear();
        chk("R10 irq drops", irq, 1'b0);
    endtask

    task automatic t_disable_r11();
        is_master = 1; sw_mss_wr = 1; sw_mss_val = 1; step();
        byte_done = 1; step();
        enable = 0; step();
        chk("R11 disable clears flag", int_flag, 1'b0);
        chk("R11 disable releases hold", scl_hold, 1'b0);
        byte_done = 1; nack = 1; step();
        chk("R11 events ignored while off", int_flag, 1'b0);
        enable = 1; step();
        nack = 1; step();
        chk("R11 mss cleared by disable", int_flag, 1'b0);
        is_master = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; enable = 1;
        step(); step();
        t_reset_r12();
        t_before_ack_r1();
        t_after_ack_r2();
        t_arb_r3_r4();
        t_nack_r5();
        t_rx_r6();
        t_sw_r7();
        t_stop_r8();
        t_rsc_r9();
        t_irq_r10();
        t_disable_r11();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule